// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the command front end of a serial flash device, reduced to the part that owns the 8-bit status register. An SPI host frames each transaction with an active-low chip select. The first byte is an opcode, sent MSB first on SI and sampled on rising SCK. SO changes on falling SCK. Both SPI mode 0 and mode 3 idle levels are accepted. Four commands are decoded: set the write-enable latch, clear it, read the status register, and write the status register.

The SCK, chip-select, SI and write-protect pins are sampled by a synchronizer into the block clock domain, and all frame logic runs on that clock. An accepted status write starts a countdown timer that stands in for the nonvolatile programming time. While it runs, the busy flag reads 1 and only the read command is honoured. When the timer expires, the busy flag and the write-enable latch clear together. A lock bit in the register works together with the active-low write-protect pin to refuse status writes.

Top module: `spi_sr_ctrl`

## Requirements
- R1: Status layout: bit 0 busy (write in progress), bit 1 write-enable latch, bits 4:2 protect field, bits 6:5 always read 0, bit 7 write lock. Opcode 05h returns this byte on SO, MSB first. Each bit changes after a falling SCK and is valid at the next rising SCK, in either SPI mode 0 or mode 3.
- R2: After opcode 05h, the status byte repeats back to back for as long as cs_n stays low.
- R3: so_oe is 0 while cs_n is high and throughout the opcode byte of every frame.
- R4: Opcode 06h sets the write-enable latch. Opcode 04h clears it.
- R5: A state-changing command acts only when cs_n rises on a byte boundary after exactly its own length: 1 byte for 06h and 04h, 2 bytes for 01h. Extra bits, extra bytes or missing bytes leave the status unchanged.
- R6: A status write (opcode 01h followed by one data byte) is ignored when the write-enable latch is 0.
- R7: A status write updates only bit 7 and bits 4:2 from its data byte. The data bits that land on bits 6:5, 1 and 0 have no effect.
- R8: When bit 7 is 1 and wp_n is low, a status write is rejected: no busy period starts and the latch is kept. When bit 7 is 0, wp_n has no effect.
- R9: An accepted status write sets the busy bit for BUSY_CYCLES clock cycles. Afterwards the busy bit and the write-enable latch are both 0.
- R10: While busy is 1, every opcode except 05h is ignored, and 05h still works.
- R11: An unknown opcode, and everything after it up to the rise of cs_n, has no effect.
- R12: After reset, every status bit is 0 and so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must run well above SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select framing each command |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low hardware write protect |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |

## Verification
The bench builds the block with BUSY_CYCLES at 2000 and SYNC_STAGES at 2, and runs SCK at eight block clocks per half period. A 2000-cycle busy window is long enough for several complete frames to fit inside it: a read that sees busy=1, a refused latch clear, and a refused second status write. It is also short enough that the bench can wait it out and confirm that busy and the latch clear together. Two synchronizer stages keep the SO update inside a single SCK half period, so every streamed bit can be sampled just before the next rising edge.

// File: rtl/spi_sr_pkg.sv
// Shared opcodes, status bit positions and the command state type.
package spi_sr_pkg;
    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_READ_SR = 8'h05;
    localparam logic [7:0] OP_WRITE_SR = 8'h01;

    localparam int SR_W = 8;
    localparam int PROT_W = 3;
    localparam int PROT_LSB = 2;
    localparam int LOCK_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_READ,
        ST_SET_WEL,
        ST_CLR_WEL,
        ST_WR_DATA,
        ST_WR_ARMED,
        ST_DROP
    } cmd_state_e;
endpackage

// File: rtl/spi_sr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each pin holds steady far longer than STAGES clock periods.
module spi_sr_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the pin values through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sr_rx.sv
// Frame and receive path. Detects SCK and chip-select edges on the
// synchronized pins, assembles bytes MSB first on rising SCK, and reports
// whether the frame ended on a byte boundary. Assumes cs_n and SCK never
// change in the same synchronized cycle.
module spi_sr_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              si_s,
    output logic              sck_fall,
    output logic              frame_start,
    output logic              frame_end,
    output logic              frame_aligned,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_q;
    logic              cs_q;
    logic              sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign sck_rise    = ~cs_n_s & sck_s & ~sck_q;
    assign sck_fall    = ~cs_n_s & ~sck_s & sck_q;
    assign frame_start = cs_q & ~cs_n_s;
    assign frame_end   = ~cs_q & cs_n_s;
    assign frame_aligned = (bit_cnt == '0);

    // Remember the previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Shift SI in on rising SCK and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[BYTE_W-2:0], si_s};
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {shreg[BYTE_W-2:0], si_s};
                end
            end
        end
    end

    AST_BYTE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> frame_aligned) else $error("byte flagged off boundary"); // R5
endmodule

// File: rtl/spi_sr_busy_timer.sv
// Countdown that models the status-write busy period. busy is high for
// exactly CYCLES clock cycles after start; done marks the last of them.
module spi_sr_busy_timer #(
    parameter int CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    AST_TIMER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy) else $error("timer did not start"); // R9
    AST_TIMER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - CW'(1))) else $error("timer skipped"); // R9
endmodule

// File: rtl/spi_sr_tx.sv
// Read-back path. While the command logic is in the read state, each
// falling SCK drives the next status bit MSB first. A fresh snapshot of
// the register is taken at the start of every byte, so the stream repeats.
// The output enable rises only at the first falling edge after the opcode.
module spi_sr_tx #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_s,
    input  logic            frame_start,
    input  logic            sck_fall,
    input  logic            rd_active,
    input  logic [SR_W-1:0] status,
    output logic            so,
    output logic            so_oe
);
    localparam int IDX_W = $clog2(SR_W);

    logic [IDX_W-1:0] bit_idx;
    logic [SR_W-1:0]  snap;
    logic             so_q;
    logic             drive_q;

    // Step through snapshot bits on falling SCK during a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            snap    <= '0;
            so_q    <= 1'b0;
            drive_q <= 1'b0;
        end else if (cs_n_s || frame_start) begin
            bit_idx <= '0;
            drive_q <= 1'b0;
        end else if (rd_active && sck_fall) begin
            drive_q <= 1'b1;
            bit_idx <= bit_idx + IDX_W'(1);
            if (bit_idx == '0) begin
                snap <= status;
                so_q <= status[SR_W-1];
            end else begin
                so_q <= snap[IDX_W'(SR_W - 1) - bit_idx];
            end
        end
    end

    assign so    = so_q;
    assign so_oe = drive_q;

    AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe) else $error("so driven while deselected"); // R3
    AST_SO_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !sck_fall) |=> $stable(so)) else $error("so moved without falling SCK"); // R1
endmodule

// File: rtl/spi_sr_cmd.sv
// Command decoder and status register. Decodes the opcode byte, collects
// the data byte of a status write, and commits state changes only when
// chip select rises on a byte boundary. Enforces the latch, lock/pin and
// busy rules. Assumes busy and done come from the companion timer.
module spi_sr_cmd
    import spi_sr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            frame_end,
    input  logic            frame_aligned,
    input  logic            byte_valid,
    input  logic [7:0]      rx_byte,
    input  logic            wp_n_s,
    input  logic            busy,
    input  logic            done,
    output logic            wr_start,
    output logic            rd_active,
    output logic [SR_W-1:0] status
);
    cmd_state_e        state;
    logic              wel;
    logic [PROT_W-1:0] prot;
    logic              lock;
    logic [PROT_W-1:0] data_prot;
    logic              data_lock;
    logic              commit;
    logic              locked_out;

    assign commit     = frame_end && frame_aligned;
    assign locked_out = lock && !wp_n_s;
    assign wr_start   = commit && (state == ST_WR_ARMED) && wel && !locked_out;
    assign rd_active  = (state == ST_READ);

    // Track the frame through opcode, data and trailing bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            data_prot <= '0;
            data_lock <= 1'b0;
        end else if (frame_end) begin
            state <= ST_IDLE;
        end else if (frame_start) begin
            state <= ST_OPCODE;
        end else if (byte_valid) begin
            unique case (state)
                ST_OPCODE: begin
                    if (busy && rx_byte != OP_READ_SR) begin
                        state <= ST_DROP;
                    end else begin
                        unique case (rx_byte)
                            OP_READ_SR:  state <= ST_READ;
                            OP_SET_WEL:  state <= ST_SET_WEL;
                            OP_CLR_WEL:  state <= ST_CLR_WEL;
                            OP_WRITE_SR: state <= ST_WR_DATA;
                            default:     state <= ST_DROP;
                        endcase
                    end
                end
                ST_WR_DATA: begin
                    state     <= ST_WR_ARMED;
                    data_prot <= rx_byte[PROT_LSB +: PROT_W];
                    data_lock <= rx_byte[LOCK_BIT];
                end
                ST_SET_WEL, ST_CLR_WEL, ST_WR_ARMED: state <= ST_DROP;
                default: state <= state;
            endcase
        end
    end

    // Write-enable latch: set/clear by command, cleared when busy ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wel <= 1'b0;
        else if (done)                               wel <= 1'b0;
        else if (commit && state == ST_SET_WEL)      wel <= 1'b1;
        else if (commit && state == ST_CLR_WEL)      wel <= 1'b0;
    end

    // Writable fields: protect bits and lock bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= '0;
            lock <= 1'b0;
        end else if (wr_start) begin
            prot <= data_prot;
            lock <= data_lock;
        end
    end

    assign status = {lock, 2'b00, prot, wel, busy};

    AST_WEL_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(state == ST_SET_WEL && commit)) else $error("latch set without command"); // R4
    AST_WEL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel) else $error("latch survived busy end"); // R9
    AST_FIELDS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(prot) && $stable(lock))) else $error("fields changed while busy"); // R10
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !wp_n_s) |=> ($stable(prot) && $stable(lock) && !$rose(busy))) else $error("locked write went through"); // R8
endmodule

// File: rtl/spi_sr_ctrl.sv
// Top: serial-flash status register controller. Synchronizes the SPI and
// write-protect pins into clk, then wires receive, command, busy timer and
// read-back paths. Assumes clk is at least eight times faster than SCK.
module spi_sr_ctrl #(
    parameter int BUSY_CYCLES = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    import spi_sr_pkg::*;

    localparam int PIN_N = 4;
    localparam logic [PIN_N-1:0] PIN_RST = 4'b1100; // {cs_n, wp_n, sck, si}

    logic [PIN_N-1:0] pins_s;
    logic             cs_n_s, wp_n_s, sck_s, si_s;
    logic             sck_fall, frame_start, frame_end, frame_aligned;
    logic             byte_valid;
    logic [7:0]       rx_byte;
    logic             busy, done, wr_start, rd_active;
    logic [SR_W-1:0]  status;

    spi_sr_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, wp_n, sck, si}), .q(pins_s)
    );
    assign {cs_n_s, wp_n_s, sck_s, si_s} = pins_s;

    spi_sr_rx #(.BYTE_W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .si_s(si_s),
        .sck_fall(sck_fall), .frame_start(frame_start), .frame_end(frame_end),
        .frame_aligned(frame_aligned), .byte_valid(byte_valid), .rx_byte(rx_byte)
    );

    spi_sr_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .frame_aligned(frame_aligned), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .wp_n_s(wp_n_s), .busy(busy), .done(done), .wr_start(wr_start),
        .rd_active(rd_active), .status(status)
    );

    spi_sr_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(done)
    );

    spi_sr_tx #(.SR_W(SR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .frame_start(frame_start),
        .sck_fall(sck_fall), .rd_active(rd_active), .status(status),
        .so(so), .so_oe(so_oe)
    );

    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(status[1])) else $error("busy without latch"); // R6
endmodule

// File: tb/spi_sr_ctrl_tb_top.sv
// Scoreboard bench: read tasks queue expected status bytes, a monitor
// pops and compares them against the bytes captured from SO.
module spi_sr_ctrl_tb_top;
    localparam int BUSY = 2000;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so, so_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    spi_sr_ctrl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cs_low(input bit mode3);
        sck = mode3;
        wait_clk(H);
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_high(input bit mode3);
        if (!mode3) sck = 1'b0;
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    // One byte, MSB first; optionally confirms so_oe stays low throughout.
    task automatic xfer_byte(input logic [7:0] tx, input int nbits, output logic [7:0] rx, output bit oe_seen);
        rx = '0;
        oe_seen = 1'b0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sck = 1'b0;
            si = tx[i];
            wait_clk(H);
            rx[i] = so;
            if (so_oe) oe_seen = 1'b1;
            sck = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic send(input int nbytes, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input int extra_bits);
        logic [7:0] r;
        bit o;
        logic [7:0] bytes [3];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        cs_low(1'b0);
        for (int k = 0; k < nbytes; k++) xfer_byte(bytes[k], 8, r, o);
        if (extra_bits > 0) xfer_byte(8'hFF, extra_bits, r, o);
        cs_high(1'b0);
    endtask

    // Read-status frame: queue expected bytes, capture streamed bytes.
    task automatic rdsr(input int nbytes, input bit mode3, input logic [7:0] exp, input string req);
        logic [7:0] r;
        bit o;
        cs_low(mode3);
        xfer_byte(spi_sr_pkg::OP_READ_SR, 8, r, o);
        chk("R3", "so_oe during opcode", {7'd0, o}, 8'h00);
        for (int k = 0; k < nbytes; k++) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
            xfer_byte(8'h00, 8, r, o);
            got_q.push_back(r);
        end
        cs_high(mode3);
        chk("R3", "so_oe after deselect", {7'd0, so_oe}, 8'h00);
    endtask

    // Monitor: compare captured bytes against the expectation queue.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "status byte", g, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        wait_clk(10);
        chk("R12", "so_oe in reset", {7'd0, so_oe}, 8'h00);
        rst_n = 1'b1;
        wait_clk(10);

        rdsr(1, 1'b0, 8'h00, "R12");                 // reset status
        send(2, 8'h01, 8'h9C, 8'h00, 0);             // R6 write with latch clear
        rdsr(1, 1'b0, 8'h00, "R6");
        send(1, 8'h06, 8'h00, 8'h00, 0);             // R4 set latch
        rdsr(1, 1'b0, 8'h02, "R4");
        rdsr(1, 1'b1, 8'h02, "R1");                  // mode 3 read
        send(1, 8'h04, 8'h00, 8'h00, 0);             // R4 clear latch
        rdsr(1, 1'b0, 8'h00, "R4");
        send(1, 8'h06, 8'h00, 8'h00, 3);             // R5 extra bits
        rdsr(1, 1'b0, 8'h00, "R5");
        send(2, 8'h06, 8'h00, 8'h00, 0);             // R5 extra byte
        rdsr(1, 1'b0, 8'h00, "R5");
        send(2, 8'h07, 8'h06, 8'h00, 0);             // R11 unknown opcode
        rdsr(1, 1'b0, 8'h00, "R11");
        send(1, 8'h06, 8'h00, 8'h00, 0);
        send(3, 8'h01, 8'h9C, 8'h00, 0);             // R5 status write too long
        rdsr(1, 1'b0, 8'h02, "R5");
        send(1, 8'h01, 8'h00, 8'h00, 0);             // R5 status write too short
        rdsr(1, 1'b0, 8'h02, "R5");

        send(2, 8'h01, 8'hFF, 8'h00, 0);             // R7 accepted, all ones
        rdsr(1, 1'b0, 8'h9F, "R7");
        send(1, 8'h04, 8'h00, 8'h00, 0);             // R10 clear ignored while busy
        send(2, 8'h01, 8'h00, 8'h00, 0);             // R10 write ignored while busy
        rdsr(1, 1'b0, 8'h9F, "R10");
        wait_clk(BUSY + 200);
        rdsr(1, 1'b0, 8'h9C, "R9");                  // busy and latch cleared

        wp_n = 1'b0;                                 // R8 locked out
        send(1, 8'h06, 8'h00, 8'h00, 0);
        send(2, 8'h01, 8'h00, 8'h00, 0);
        rdsr(1, 1'b0, 8'h9E, "R8");
        wp_n = 1'b1;
        send(2, 8'h01, 8'h00, 8'h00, 0);
        rdsr(1, 1'b0, 8'h03, "R9");
        wait_clk(BUSY + 200);
        rdsr(1, 1'b0, 8'h00, "R9");

        wp_n = 1'b0;                                 // R8 pin ignored when unlocked
        send(1, 8'h06, 8'h00, 8'h00, 0);
        send(2, 8'h01, 8'h0C, 8'h00, 0);
        rdsr(1, 1'b0, 8'h0F, "R8");
        wait_clk(BUSY + 200);
        wp_n = 1'b1;
        rdsr(4, 1'b0, 8'h0C, "R2");                  // streamed repeat

        wait_clk(20);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule